// File: doc/BRIEF.md
# Oversampled Blind Clock Data Recovery

This block recovers the bits of a serial stream of about 480 Mb/s from raw line samples taken at five times the bit rate. No PLL or DLL follows the incoming data, and nothing is fed back to the sampling clock. Each clock cycle brings one word of five consecutive samples, which is one nominal unit interval. The block marks where the data transitions fall, counts them by position over a fixed window, and picks the sample that lies farthest from the transitions, in the middle of the eye.

The chosen phase can creep past the word boundary when the transmitter runs slightly fast or slow. An add-drop buffer absorbs this. When the phase crosses the boundary one way, that cycle gives no bit. When it crosses the other way, that cycle gives two bits. The buffer sits at half occupancy and releases zero, one or two recovered bits per cycle, with a count of how many are valid.

Top module: `cdr_blind_recovery`

## Requirements
- R1: After reset, phaseSel is 2, outCount is 0 and both sticky flags are low.
- R2: Sample bit 0 of sampIn is the earliest sample. An edge at position k (k = 1..4) is a change between samples k-1 and k of one word. An edge at position 0 is a change between sample 4 of the previous word and sample 0 of the current word. At the end of each window, the target phase is (most-hit edge position + 2) mod 5, and the lowest position wins a tie.
- R3: phaseSel changes only at the end of a window of WIN cycles (default 16). It moves by exactly one step, with wrap, along the shorter way round towards the target.
- R4: A window in which no edge was seen leaves phaseSel unchanged, even when the phase is not 2.
- R5: The first cycle after phaseSel wraps from 4 to 0 adds no bit to the buffer. The first cycle after it wraps from 0 to 4 adds two bits, sample 0 before sample 4. Every other cycle adds one bit, the sample at phaseSel.
- R6: The buffer holds 8 bits. Each cycle it releases two bits when it holds 6 or more, one bit when it holds 5, and none when it holds 4 or fewer. outBits[0] is the older bit, and outCount (0, 1 or 2) says how many bits are valid. With a constant phase, exactly one bit per cycle comes out in steady state.
- R7: The recovered stream equals the transmitted stream under a fixed sampling offset, under a rate error of plus or minus 400 ppm, and under random one-sample edge jitter.
- R8: overflowFlag sets and stays set when a bit cannot be stored. underflowFlag sets and stays set when the buffer empties after it has once held more than half. Both flags stay low for valid input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock, one nominal unit interval per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| sampIn | input | 5 | Five line samples of one unit interval, bit 0 earliest |
| outBits | output | 2 | Recovered bits, bit 0 older |
| outCount | output | 2 | Number of valid bits in outBits |
| phaseSel | output | 3 | Sample phase currently used as the eye centre |
| overflowFlag | output | 1 | Sticky: a bit was lost because the buffer was full |
| underflowFlag | output | 1 | Sticky: the buffer ran empty after priming |

## Verification
The assertions rely on the incoming stream staying within a few hundred ppm of the nominal rate, with edges that wander by no more than one sample. Under that limit at most one phase wrap happens per window, the buffer stays near half full, and the no-overflow and no-underflow properties must hold. The bench builds every sample from a line model that uses exact integer arithmetic for the bit period. It adds rate errors of plus or minus 400 ppm and one-sample jitter on a small share of the samples, and it drives only clean, edge-aligned patterns in the phase-step table.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
  localparam int OSR    = 5;
  localparam int SEL_W  = $clog2(OSR);
  localparam int CENTRE = OSR / 2;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             dropBit;
    logic             dblBit;
  } phase_ctrl_t;
endpackage

// File: rtl/cdr_phase_ctrl.sv
module cdr_phase_ctrl
  import cdr_pkg::*;
#(
  parameter int WIN = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [OSR-1:0] edgeHits,
  output phase_ctrl_t    ctrl
);
  localparam int WCW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int CW  = $clog2(WIN + 1);

  logic [WCW-1:0]   winCnt;
  logic             winEnd;
  logic [CW-1:0]    hitCnt  [OSR];
  logic [CW-1:0]    nextCnt [OSR];
  logic [SEL_W-1:0] selQ;
  logic             dropQ, dblQ;
  int               best, target, fwd;
  logic             quiet, stepUp, stepDn;

  assign winEnd = (winCnt == WCW'(WIN - 1));

  always_comb begin
    for (int i = 0; i < OSR; i++) nextCnt[i] = hitCnt[i] + CW'(edgeHits[i]);
  end

  // vote: strictly greater wins, so the lowest position keeps a tie
  always_comb begin
    best = 0;
    for (int i = 1; i < OSR; i++)
      if (nextCnt[i] > nextCnt[best]) best = i;
    quiet  = (nextCnt[best] == '0);
    target = (best + CENTRE) % OSR;
    fwd    = (target - int'(selQ) + OSR) % OSR;
    stepUp = !quiet && (fwd != 0) && (fwd <= CENTRE);
    stepDn = !quiet && (fwd > CENTRE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt <= '0;
      selQ   <= SEL_W'(CENTRE);
      dropQ  <= 1'b0;
      dblQ   <= 1'b0;
      for (int i = 0; i < OSR; i++) hitCnt[i] <= '0;
    end else begin
      winCnt <= winEnd ? '0 : winCnt + 1'b1;
      dropQ  <= 1'b0;
      dblQ   <= 1'b0;
      for (int i = 0; i < OSR; i++) hitCnt[i] <= winEnd ? '0 : nextCnt[i];
      if (winEnd && stepUp) begin
        if (selQ == SEL_W'(OSR - 1)) begin
          selQ  <= '0;
          dropQ <= 1'b1;
        end else begin
          selQ <= selQ + 1'b1;
        end
      end else if (winEnd && stepDn) begin
        if (selQ == '0) begin
          selQ <= SEL_W'(OSR - 1);
          dblQ <= 1'b1;
        end else begin
          selQ <= selQ - 1'b1;
        end
      end
    end
  end

  assign ctrl = '{sel: selQ, dropBit: dropQ, dblBit: dblQ};

  p_sel_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !winEnd |=> $stable(selQ));

  p_sel_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (selQ != $past(selQ)) |->
      (((int'(selQ) + 1) % OSR == int'($past(selQ))) ||
       ((int'($past(selQ)) + 1) % OSR == int'(selQ))));

  p_drop_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    dropQ |-> (selQ == '0 && $past(selQ) == SEL_W'(OSR - 1)));

  p_dbl_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    dblQ |-> (selQ == SEL_W'(OSR - 1) && $past(selQ) == '0));
endmodule

// File: rtl/cdr_datapath.sv
module cdr_datapath
  import cdr_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [OSR-1:0] sampIn,
  input  phase_ctrl_t    ctrl,
  output logic [OSR-1:0] edgeHits,
  output logic [1:0]     outBits,
  output logic [1:0]     outCount,
  output logic           overflowFlag,
  output logic           underflowFlag
);
  localparam int PW   = $clog2(DEPTH);
  localparam int OW   = PW + 1;
  localparam int HALF = DEPTH / 2;

  logic [OSR-1:0]   wordQ;
  logic             lastQ;
  logic [DEPTH-1:0] mem;
  logic [PW-1:0]    wrPtr, rdPtr;
  logic [OW-1:0]    occ;
  logic             primedQ;
  int               pushN, popN, accN, occNext;
  logic             bit0, bit1;

  // edge position 0 straddles the word boundary
  assign edgeHits[0] = lastQ ^ wordQ[0];
  generate
    for (genvar g = 1; g < OSR; g++) begin : g_edge
      assign edgeHits[g] = wordQ[g-1] ^ wordQ[g];
    end
  endgenerate

  always_comb begin
    bit0  = wordQ[ctrl.sel];
    bit1  = 1'b0;
    pushN = 1;
    if (ctrl.dropBit) begin
      pushN = 0;
    end else if (ctrl.dblBit) begin
      pushN = 2;
      bit0  = wordQ[0];
      bit1  = wordQ[OSR-1];
    end
    if (int'(occ) >= HALF + 2)   popN = 2;
    else if (int'(occ) > HALF)   popN = 1;
    else                         popN = 0;
    accN    = (pushN <= DEPTH - int'(occ) + popN) ? pushN : DEPTH - int'(occ) + popN;
    occNext = int'(occ) - popN + accN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordQ         <= '0;
      lastQ         <= 1'b0;
      mem           <= '0;
      wrPtr         <= '0;
      rdPtr         <= '0;
      occ           <= '0;
      primedQ       <= 1'b0;
      outBits       <= '0;
      outCount      <= '0;
      overflowFlag  <= 1'b0;
      underflowFlag <= 1'b0;
    end else begin
      wordQ <= sampIn;
      lastQ <= wordQ[OSR-1];
      if (accN >= 1) mem[wrPtr] <= bit0;
      if (accN == 2) mem[wrPtr + PW'(1)] <= bit1;
      wrPtr    <= wrPtr + PW'(accN);
      rdPtr    <= rdPtr + PW'(popN);
      occ      <= OW'(occNext);
      outBits  <= {mem[rdPtr + PW'(1)], mem[rdPtr]};
      outCount <= 2'(popN);
      if (int'(occ) > HALF) primedQ <= 1'b1;
      if (accN < pushN) overflowFlag <= 1'b1;
      if (primedQ && occNext == 0) underflowFlag <= 1'b1;
    end
  end

  p_occ_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    occ <= OW'(DEPTH));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    accN == pushN);

  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    primedQ |-> (occ != '0));
endmodule

// File: rtl/cdr_blind_recovery.sv
module cdr_blind_recovery
  import cdr_pkg::*;
#(
  parameter int WIN   = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [OSR-1:0]   sampIn,
  output logic [1:0]       outBits,
  output logic [1:0]       outCount,
  output logic [SEL_W-1:0] phaseSel,
  output logic             overflowFlag,
  output logic             underflowFlag
);
  phase_ctrl_t    ctrl;
  logic [OSR-1:0] edgeHits;

  cdr_phase_ctrl #(.WIN(WIN)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .edgeHits (edgeHits),
    .ctrl     (ctrl)
  );

  cdr_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .sampIn        (sampIn),
    .ctrl          (ctrl),
    .edgeHits      (edgeHits),
    .outBits       (outBits),
    .outCount      (outCount),
    .overflowFlag  (overflowFlag),
    .underflowFlag (underflowFlag)
  );

  assign phaseSel = ctrl.sel;
endmodule

// File: tb/sim_cdr_blind_recovery.sv
`timescale 1ns/1ps
module sim_cdr_blind_recovery;
  localparam int WIN  = 16;
  localparam int CYC  = 6000;
  localparam int LOCK = 200;
  localparam int NTX  = 8192;

  // phase-step table: edge position (5 = no edges), windows, expected phase
  localparam int NROW = 7;
  localparam int ROW_P   [NROW] = '{0, 1, 2, 3, 5, 1, 4};
  localparam int ROW_N   [NROW] = '{1, 1, 2, 2, 2, 2, 1};
  localparam int ROW_EXP [NROW] = '{2, 3, 4, 0, 0, 3, 2};

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] sampIn = '0;
  logic [1:0] outBits;
  logic [1:0] outCount;
  logic [2:0] phaseSel;
  logic       overflowFlag, underflowFlag;

  int nChecks = 0;
  int nErr    = 0;
  bit txBit [NTX];
  bit rec   [NTX];

  always #2.5 clk = ~clk;

  cdr_blind_recovery #(.WIN(WIN), .DEPTH(8)) u0 (
    .clk(clk), .rstN(rstN), .sampIn(sampIn), .outBits(outBits),
    .outCount(outCount), .phaseSel(phaseSel),
    .overflowFlag(overflowFlag), .underflowFlag(underflowFlag)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN   = 1'b0;
    sampIn = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  function automatic int bitIdx(longint j, int off, int ppm);
    return int'(((j + longint'(off)) * 64'sd1000000) / (64'sd5 * (64'sd1000000 + longint'(ppm))));
  endfunction

  task automatic runStream(input int off, input int ppm, input bit jit, input string name,
                           output bit sawDrop, output bit sawDbl,
                           output bit sawZero, output bit sawTwo, output int notOne);
    int  nRec;
    int  found;
    int  errs;
    int  prevSel;
    logic [4:0] wd;
    nRec = 0; sawDrop = 0; sawDbl = 0; sawZero = 0; sawTwo = 0; notOne = 0;
    doReset();
    prevSel = int'(phaseSel);
    for (int c = 0; c < CYC; c++) begin
      @(negedge clk);
      if (prevSel == 4 && phaseSel == 3'd0) sawDrop = 1;
      if (prevSel == 0 && phaseSel == 3'd4) sawDbl = 1;
      prevSel = int'(phaseSel);
      if (c >= LOCK) begin
        if (outCount == 2'd0) sawZero = 1;
        if (outCount == 2'd2) sawTwo = 1;
        if (outCount != 2'd1) notOne++;
        for (int b = 0; b < int'(outCount); b++) begin
          if (nRec < NTX) rec[nRec] = outBits[b];
          nRec++;
        end
      end
      for (int i = 0; i < 5; i++) begin
        longint j;
        j = longint'(c) * 5 + i;
        if (jit && ($urandom % 8 == 0)) begin
          if ($urandom % 2 == 1) j = j + 1;
          else if (j > 0) j = j - 1;
        end
        wd[i] = txBit[bitIdx(j, off, ppm)];
      end
      sampIn = wd;
    end
    found = -1;
    for (int k0 = 0; k0 < 4000 && found < 0; k0++) begin
      bit ok;
      ok = 1;
      for (int m = 0; m < 64; m++) if (rec[m] != txBit[k0 + m]) ok = 0;
      if (ok) found = k0;
    end
    check(found >= 0, {"R7 alignment ", name}, found, 0);
    errs = 0;
    if (found >= 0)
      for (int m = 0; m < nRec && found + m < NTX; m++)
        if (rec[m] != txBit[found + m]) errs++;
    check(errs == 0, {"R7 bit errors ", name}, errs, 0);
    check(overflowFlag == 1'b0, {"R8 overflow ", name}, int'(overflowFlag), 0);
    check(underflowFlag == 1'b0, {"R8 underflow ", name}, int'(underflowFlag), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    bit [6:0] lfsr;
    bit v;
    bit dA, uA, zA, tA, dB, uB, zB, tB, dC, uC, zC, tC;
    int nA, nB, nC;
    logic [4:0] wd;
    int lastP;

    lfsr = 7'h5A;
    for (int k = 0; k < NTX; k++) begin
      txBit[k] = lfsr[6];
      lfsr = {lfsr[5:0], lfsr[6] ^ lfsr[5]};
    end

    // R1: reset state
    doReset();
    check(phaseSel == 3'd2, "R1 phaseSel", int'(phaseSel), 2);
    check(outCount == 2'd0, "R1 outCount", int'(outCount), 0);
    check(overflowFlag == 1'b0, "R1 overflowFlag", int'(overflowFlag), 0);
    check(underflowFlag == 1'b0, "R1 underflowFlag", int'(underflowFlag), 0);

    // R2 R3 R4: edge position table walked by one loop
    v = 1'b0;
    lastP = 0;
    for (int r = 0; r < NROW; r++) begin
      for (int c = 0; c < ROW_N[r] * WIN; c++) begin
        @(negedge clk);
        if (c == 4 && r > 0)
          check(int'(phaseSel) == ROW_EXP[r-1],
                (ROW_P[r-1] == 5) ? "R4 quiet window" : "R2 R3 phase step",
                int'(phaseSel), ROW_EXP[r-1]);
        if (ROW_P[r] == 5) begin
          wd = {5{v}};
        end else begin
          for (int i = 0; i < 5; i++) wd[i] = (i < ROW_P[r]) ? v : ~v;
          v = ~v;
        end
        sampIn = wd;
      end
      lastP = ROW_P[r];
    end
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      for (int i = 0; i < 5; i++) wd[i] = (i < lastP) ? v : ~v;
      v = ~v;
      sampIn = wd;
    end
    check(int'(phaseSel) == ROW_EXP[NROW-1], "R2 R3 final phase step",
          int'(phaseSel), ROW_EXP[NROW-1]);

    // fixed offset, no drift: steady one bit per cycle
    runStream(2, 0, 1'b0, "offset", dA, uA, zA, tA, nA);
    check(nA == 0, "R6 one bit per cycle", nA, 0);
    check(dA == 0 && uA == 0, "R3 no wrap at fixed offset", int'(dA) + int'(uA), 0);

    // slow transmitter: phase climbs and wraps 4 to 0
    runStream(0, 400, 1'b1, "slow", dB, uB, zB, tB, nB);
    check(dB == 1, "R5 wrap 4 to 0 seen", int'(dB), 1);
    check(zB == 1, "R5 empty output cycle after drop", int'(zB), 1);

    // fast transmitter: phase falls and wraps 0 to 4
    runStream(3, -400, 1'b1, "fast", dC, uC, zC, tC, nC);
    check(uC == 1, "R5 wrap 0 to 4 seen", int'(uC), 1);
    check(tC == 1, "R6 two-bit output after double push", int'(tC), 1);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule